// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address by reading a three-level radix page table from memory. A requester hands over one address at a time with the kind of access (load, store or instruction fetch) and the privilege level it runs at. In supervisor and user mode the walker reads one 64-bit entry per level, starting from the table whose page number comes from a root configuration input. It then returns either the translated address or a page fault. In machine mode the address is returned unchanged without touching memory.

The memory side is a single read channel: an address with a valid/ready handshake, followed some cycles later by a one-cycle data strobe. Request and response use valid/ready handshakes. Only one translation is in flight at any time.

Top module: `pt_walker3`

## Requirements
- R1: With `req_priv` = 3 (machine), the response appears in the cycle after acceptance. It carries no fault, `resp_paddr` is the virtual address zero-extended to 56 bits, and no memory read is issued.
- R2: With `req_priv` = 0 (user) or 1 (supervisor) and `root_cfg` equal to zero, the response is a fault in the cycle after acceptance, and no memory read is issued.
- R3: The first entry read is at {root_cfg[43:0], va[38:30], 3'b000}. The second is at {first entry PPN, va[29:21], 3'b000}. The third is at {second entry PPN, va[20:12], 3'b000}. A walk never issues more than three reads.
- R4: The entry layout is: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bits [53:10] PPN. An entry with bit 0 clear ends the walk at once with a fault.
- R5: A valid entry with the write bit set and the read bit clear ends the walk with a fault.
- R6: A valid entry with read, write and execute all clear is a pointer to the next level. A pointer read at the third level gives a fault.
- R7: A valid entry with any of read/write/execute set that is read at the first or second level gives a fault, and no further read is issued.
- R8: A third-level entry must grant the access: `req_acc` 0 (load) needs the read bit, 1 (store) needs the write bit, 2 (fetch) needs the execute bit. Otherwise the walk faults.
- R9: A user-mode request (`req_priv` = 0) faults unless the third-level entry has the user bit set. Supervisor requests ignore the user bit.
- R10: A walk that passes every check returns {third-level entry PPN, va[11:0]} with no fault.
- R11: `req_ready` is high only while no translation is in progress. A pending response holds its value until `resp_ready`. A pending memory request holds its address until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| req_vaddr | input | 39 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| root_cfg | input | 64 | Root table configuration, PPN in [43:0], zero = unconfigured |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Entry returned by memory |
| resp_valid | output | 1 | Translation result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_paddr | output | 56 | Physical address |
| resp_fault | output | 1 | Page fault |

## Verification
The hardest case to reach is a walk that reaches its third level with a particular combination of leaf flags, access kind and privilege. That combination is only reached after two correct pointer entries have been returned at the right addresses. The bench's memory model therefore serves a chain of three entries per translation. The pointers carry varying page numbers, and the leaf sweeps all sixteen read/write/execute/user patterns against every access kind in both user and supervisor mode. Separate chains place faults, pointers and leaves at the earlier levels. Memory stalls of several lengths are applied to both halves of the read handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_M = 2'd3;

   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MREQ  = 2'd1,
      ST_MWAIT = 2'd2,
      ST_RESP  = 2'd3
   } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int LEVELS = 3,
   parameter int IDX_W  = 9,
   parameter int PPN_W  = 44,
   parameter int ENT_B  = 3,
   parameter int LVL_W  = 2,
   localparam int VPN_W = LEVELS * IDX_W,
   localparam int ADR_W = PPN_W + IDX_W + ENT_B
) (
   input  logic [PPN_W-1:0] base_ppn,
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] level,
   output logic [ADR_W-1:0] ent_addr
);
   logic [IDX_W-1:0] idx [LEVELS];
   logic [IDX_W-1:0] idx_sel;

   for (genvar g = 0; g < LEVELS; g++) begin : g_idx
      assign idx[g] = vpn[g*IDX_W +: IDX_W];
   end

   always_comb begin
      idx_sel = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (level == LVL_W'(i)) idx_sel = idx[i];
      end
   end

   assign ent_addr = {base_ppn, idx_sel, {ENT_B{1'b0}}};
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
   import ptw_pkg::*;
#(
   parameter int PTE_W   = 64,
   parameter int PPN_W   = 44,
   parameter int PPN_LSB = 10
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             last_lvl,
   input  logic [1:0]       acc,
   input  logic [1:0]       priv,
   output logic             descend,
   output logic             leaf_ok,
   output logic [PPN_W-1:0] ppn
);
   if (PPN_LSB + PPN_W > PTE_W) begin : g_bad_layout
      $error("entry PPN field exceeds entry width");
   end

   logic f_v, f_r, f_w, f_x, f_u;
   logic is_ptr, malformed, perm, user_ok;

   assign f_v = pte[0];
   assign f_r = pte[1];
   assign f_w = pte[2];
   assign f_x = pte[3];
   assign f_u = pte[4];
   assign ppn = pte[PPN_LSB +: PPN_W];

   assign is_ptr    = f_v & ~f_r & ~f_w & ~f_x;
   assign malformed = ~f_v | (f_w & ~f_r);

   always_comb begin
      unique case (acc)
         ACC_LOAD:  perm = f_r;
         ACC_STORE: perm = f_w;
         ACC_FETCH: perm = f_x;
         default:   perm = 1'b0;
      endcase
   end

   assign user_ok = (priv != PRV_U) | f_u;
   assign descend = ~malformed & is_ptr & ~last_lvl;
   assign leaf_ok = ~malformed & ~is_ptr & last_lvl & perm & user_ok;

   logic unused_fields;
   assign unused_fields = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:5]};
endmodule

// File: rtl/pt_walker3.sv
module pt_walker3
   import ptw_pkg::*;
#(
   parameter int VA_W    = 39,
   parameter int PA_W    = 56,
   parameter int PTE_W   = 64,
   parameter int CFG_W   = 64,
   parameter int LEVELS  = 3,
   parameter int IDX_W   = 9,
   parameter int OFF_W   = 12,
   parameter int PPN_LSB = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_acc,
   input  logic [1:0]       req_priv,
   input  logic [CFG_W-1:0] root_cfg,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             resp_valid,
   input  logic             resp_ready,
   output logic [PA_W-1:0]  resp_paddr,
   output logic             resp_fault
);
   localparam int PPN_W = PA_W - OFF_W;
   localparam int VPN_W = LEVELS * IDX_W;
   localparam int ENT_B = $clog2(PTE_W / 8);
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

   if (VPN_W + OFF_W != VA_W) begin : g_bad_va
      $error("virtual address width does not match levels and offset");
   end
   if (IDX_W + ENT_B != OFF_W) begin : g_bad_tbl
      $error("one table must fill exactly one page");
   end
   if (PA_W <= VA_W || PPN_W > CFG_W) begin : g_bad_pa
      $error("physical width inconsistent with virtual or root widths");
   end

   walk_st_e         st_q;
   logic [VPN_W-1:0] vpn_q;
   logic [OFF_W-1:0] off_q;
   logic [1:0]       acc_q, priv_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PPN_W-1:0] ppn_q;
   logic [PA_W-1:0]  pa_q;
   logic             flt_q;

   logic             req_fire, dec_descend, dec_leaf_ok;
   logic [PPN_W-1:0] dec_ppn;

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_MREQ);
   assign resp_valid    = (st_q == ST_RESP);
   assign resp_paddr    = pa_q;
   assign resp_fault    = flt_q;
   assign req_fire      = req_valid && req_ready;

   ptw_addr_gen #(
      .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .ENT_B(ENT_B), .LVL_W(LVL_W)
   ) u_addr (
      .base_ppn(ppn_q), .vpn(vpn_q), .level(lvl_q), .ent_addr(mem_req_addr)
   );

   ptw_pte_decode #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .PPN_LSB(PPN_LSB)
   ) u_dec (
      .pte(mem_rsp_data), .last_lvl(lvl_q == '0), .acc(acc_q), .priv(priv_q),
      .descend(dec_descend), .leaf_ok(dec_leaf_ok), .ppn(dec_ppn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         vpn_q  <= '0;
         off_q  <= '0;
         acc_q  <= '0;
         priv_q <= '0;
         lvl_q  <= '0;
         ppn_q  <= '0;
         pa_q   <= '0;
         flt_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_fire) begin
               vpn_q  <= req_vaddr[VA_W-1:OFF_W];
               off_q  <= req_vaddr[OFF_W-1:0];
               acc_q  <= req_acc;
               priv_q <= req_priv;
               lvl_q  <= LVL_W'(LEVELS - 1);
               ppn_q  <= root_cfg[PPN_W-1:0];
               if (req_priv == PRV_M) begin
                  pa_q  <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
                  flt_q <= 1'b0;
                  st_q  <= ST_RESP;
               end else if (root_cfg == '0) begin
                  pa_q  <= '0;
                  flt_q <= 1'b1;
                  st_q  <= ST_RESP;
               end else begin
                  st_q  <= ST_MREQ;
               end
            end
            ST_MREQ: if (mem_req_ready) st_q <= ST_MWAIT;
            ST_MWAIT: if (mem_rsp_valid) begin
               if (dec_descend) begin
                  ppn_q <= dec_ppn;
                  lvl_q <= lvl_q - 1'b1;
                  st_q  <= ST_MREQ;
               end else if (dec_leaf_ok) begin
                  pa_q  <= {dec_ppn, off_q};
                  flt_q <= 1'b0;
                  st_q  <= ST_RESP;
               end else begin
                  pa_q  <= '0;
                  flt_q <= 1'b1;
                  st_q  <= ST_RESP;
               end
            end
            ST_RESP: if (resp_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   logic [LVL_W:0] rd_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rd_cnt <= '0;
      else if (req_fire)                       rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 1'b1;
   end

   // R1
   mach_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && req_priv == PRV_M) |=> (resp_valid && !resp_fault &&
         resp_paddr == {{(PA_W-VA_W){1'b0}}, $past(req_vaddr)}));

   // R2
   zero_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && req_priv != PRV_M && root_cfg == '0) |=> (resp_valid && resp_fault));

   // R3
   walk_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |-> (rd_cnt < (LVL_W+1)'(LEVELS)));

   // R11
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!resp_valid && !mem_req_valid));

   // R11
   resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr) && $stable(resp_fault)));

   // R11
   mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/tb_pt_walker3.sv
module tb_pt_walker3;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready;
   logic [38:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0, req_priv = '0;
   logic [63:0] root_cfg = '0;
   logic        mem_req_valid, mem_req_ready;
   logic [55:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        resp_valid, resp_ready = 1'b0;
   logic [55:0] resp_paddr;
   logic        resp_fault;

   int checks = 0, fails = 0;
   int lat_cfg = 0;
   int nreads = 0;
   logic [63:0] pte_tab [3];
   logic [55:0] addr_log [4];

   always #5 clk = ~clk;

   pt_walker3 dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .req_priv(req_priv), .root_cfg(root_cfg),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid), .resp_ready(resp_ready),
      .resp_paddr(resp_paddr), .resp_fault(resp_fault)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // memory model: stalls ready and data by lat_cfg cycles
   initial begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            repeat (lat_cfg) @(negedge clk);
            mem_req_ready = 1'b1;
            if (nreads < 4) addr_log[nreads] = mem_req_addr;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (lat_cfg) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = (nreads < 3) ? pte_tab[nreads] : 64'h0;
            nreads++;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   function automatic logic [63:0] mk_ptr(input logic [43:0] ppn);
      return (64'(ppn) << 10) | 64'h1;
   endfunction

   function automatic logic [63:0] mk_ent(input logic [43:0] ppn, input logic [4:0] fl);
      return (64'(ppn) << 10) | 64'(fl);
   endfunction

   task automatic walk(input logic [38:0] va, input logic [1:0] acc, input logic [1:0] pv,
                       input logic [63:0] root, input logic [63:0] e2, input logic [63:0] e1,
                       input logic [63:0] e0, input bit exp_f, input logic [55:0] exp_pa,
                       input int exp_rd, input string tag);
      logic [55:0] ea [3];
      logic [55:0] got_pa;
      logic        got_f;
      int          wait_n;
      pte_tab[0] = e2; pte_tab[1] = e1; pte_tab[2] = e0;
      nreads = 0;
      ea[0] = {root[43:0], va[38:30], 3'b000};
      ea[1] = {e2[53:10], va[29:21], 3'b000};
      ea[2] = {e1[53:10], va[20:12], 3'b000};
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_priv = pv; root_cfg = root;
      chk(req_ready, "R11", "idle ready", 64'(req_ready), 64'h1);
      @(negedge clk);
      req_valid = 1'b0;
      // R11: no new request taken while busy
      chk(!req_ready, "R11", "busy ready", 64'(req_ready), 64'h0);
      wait_n = 0;
      while (!resp_valid && wait_n < 300) begin
         @(negedge clk);
         wait_n++;
      end
      got_pa = resp_paddr;
      got_f  = resp_fault;
      chk(resp_valid, tag, "response", 64'(resp_valid), 64'h1);
      if (exp_rd == 0)
         chk(wait_n == 0, tag, "latency", 64'(wait_n), 64'h0);
      chk(got_f == exp_f, tag, "fault", 64'(got_f), 64'(exp_f));
      if (!exp_f)
         chk(got_pa == exp_pa, tag, "paddr", 64'(got_pa), 64'(exp_pa));
      chk(nreads == exp_rd, tag, "reads", 64'(nreads), 64'(exp_rd));
      for (int k = 0; k < 3; k++) begin
         if (k < exp_rd && k < nreads)
            chk(addr_log[k] == ea[k], "R3", "entry addr", 64'(addr_log[k]), 64'(ea[k]));
      end
      @(negedge clk);
      @(negedge clk);
      chk(resp_valid && resp_paddr == got_pa && resp_fault == got_f, "R11", "held resp",
          64'(resp_paddr), 64'(got_pa));
      resp_ready = 1'b1;
      @(negedge clk);
      resp_ready = 1'b0;
   endtask

   initial begin
      #1500000;
      fails++;
      $display("FAIL R11 watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [38:0] va;
      logic [43:0] rp, p1, p0, lp;
      logic [63:0] root;
      bit          ef;
      string       tg;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(req_ready && !resp_valid && !mem_req_valid, "R11", "reset state",
          {61'b0, req_ready, resp_valid, mem_req_valid}, 64'h4);
      rst_n = 1'b1;

      // R1 machine-mode bypass, with and without a root configured
      walk(39'h7F_1234_5678, 2'd0, 2'd3, 64'h0, 0, 0, 0, 1'b0, 56'h7F_1234_5678, 0, "R1");
      walk(39'h01_0000_0ABC, 2'd2, 2'd3, 64'h555, 0, 0, 0, 1'b0, 56'h01_0000_0ABC, 0, "R1");
      // R2 unconfigured root
      walk(39'h12_3456_7000, 2'd0, 2'd1, 64'h0, 0, 0, 0, 1'b1, 0, 0, "R2");
      walk(39'h12_3456_7000, 2'd1, 2'd0, 64'h0, 0, 0, 0, 1'b1, 0, 0, "R2");

      // leaf-flag sweep at level three
      for (int lat = 0; lat < 3; lat++) begin
         lat_cfg = (lat == 2) ? 3 : lat;
         for (int pv = 0; pv < 2; pv++) begin
            for (int ac = 0; ac < 3; ac++) begin
               for (int f = 0; f < 16; f++) begin
                  int n;
                  bit r, w, x, u;
                  n  = ((lat * 2 + pv) * 3 + ac) * 16 + f;
                  va = 39'(n * 64'h0_2468_ACE1 + 64'h4_0000_0123);
                  rp = 44'h100 + 44'(n);
                  p1 = 44'hA_0000 + 44'(n * 7);
                  p0 = 44'hB_0000 + 44'(n * 13);
                  lp = 44'hF_0000_0000 + 44'(n * 97);
                  root = 64'h8000_0000_0000_0000 | 64'(rp);
                  r = f[0]; w = f[1]; x = f[2]; u = f[3];
                  ef = 1'b0; tg = "R10";
                  if (!r && !w && !x)          begin ef = 1'b1; tg = "R6"; end
                  else if (w && !r)            begin ef = 1'b1; tg = "R5"; end
                  else if ((ac == 0 && !r) || (ac == 1 && !w) || (ac == 2 && !x))
                                               begin ef = 1'b1; tg = "R8"; end
                  else if (pv == 0 && !u)      begin ef = 1'b1; tg = "R9"; end
                  walk(va, 2'(ac), 2'(pv), root, mk_ptr(p1), mk_ptr(p0),
                       mk_ent(lp, {u, x, w, r, 1'b1}), ef, {lp, va[11:0]}, 3, tg);
               end
            end
         end
      end
      lat_cfg = 1;

      // R4 invalid entries at each level
      va = 39'h55_5555_5555;
      walk(va, 2'd0, 2'd1, 64'h321, mk_ent(44'h9, 5'b11110), 0, 0, 1'b1, 0, 1, "R4");
      walk(va, 2'd0, 2'd1, 64'h321, mk_ptr(44'h77), mk_ent(44'h9, 5'b00110), 0, 1'b1, 0, 2, "R4");
      walk(va, 2'd0, 2'd1, 64'h321, mk_ptr(44'h77), mk_ptr(44'h88),
           mk_ent(44'h9, 5'b11110), 1'b1, 0, 3, "R4");
      // R5 write without read before the last level
      walk(va, 2'd1, 2'd1, 64'h321, mk_ent(44'h9, 5'b00101), 0, 0, 1'b1, 0, 1, "R5");
      // R7 leaves at the first and second levels
      walk(va, 2'd0, 2'd1, 64'h321, mk_ent(44'h9, 5'b00011), 0, 0, 1'b1, 0, 1, "R7");
      walk(va, 2'd2, 2'd0, 64'h321, mk_ptr(44'h77), mk_ent(44'h9, 5'b11001), 0, 1'b1, 0, 2, "R7");
      // R10 successful walks at the address extremes
      walk(39'h7F_FFFF_FFFF, 2'd1, 2'd0, 64'hFFF_FFFF_FFFF, mk_ptr(44'hFFF_FFFF_FFFF),
           mk_ptr(44'h0), mk_ent(44'hFFF_FFFF_FFFF, 5'b10111), 1'b0, 56'hFF_FFFF_FFFF_FFFF, 3, "R10");
      walk(39'h0, 2'd2, 2'd1, 64'h1, mk_ptr(44'h2), mk_ptr(44'h3),
           mk_ent(44'h4, 5'b01001), 1'b0, 56'h4000, 3, "R10");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule